// File: doc/BRIEF.md
# Compare, Skip, Jump and Count Execution Unit

This unit executes one family of a 36-bit word machine's instruction set. That family covers eight operations: compare with an immediate, compare with memory, test-and-jump, test-and-skip, and four count-and-test forms that add or subtract one. The decoder above it supplies the 9-bit opcode, the 4-bit accumulator number, the accumulator contents, the memory word at the effective address, the 18-bit effective address E and the current program counter. One cycle later, the unit presents a registered result word. Alongside it come write strobes for the accumulator and for memory, and the next program counter with a code for how that counter was chosen.

The opcode splits into three fields. The top three bits mark the family. The middle three bits pick the operation. The low three bits pick one of eight signed tests, and two of those tests are "never" and "always". Every test compares two values as signed two's-complement 36-bit numbers. Count operations wrap modulo 2^36. The result register feeds a shared writeback multiplexer that lies outside this block.

Top module: `csj_exec_unit`

## Requirements
- R1: An operation is accepted only when `op_valid` is 1 and `opcode[8:6]` equals 3'b011. In every other case, on the next cycle `res_valid`, `ac_we` and `mem_we` are 0 and `pc_sel` is 2'b00.
- R2: The test code `opcode[2:0]` works as follows: 000 never, 001 less, 010 equal, 011 less-or-equal, 100 always, 101 greater-or-equal, 110 not-equal, 111 greater. Each test is a signed comparison of the tested value X against the reference Y.
- R3: Operation 000 compares X = accumulator against Y = {18'b0, E}. Operation 001 compares X = accumulator against Y = memory word. A true test skips. Neither operation writes anything, and `result` is 0.
- R4: Operation 010 tests X = accumulator against Y = 0 and jumps when the test is true. It writes nothing.
- R5: Operation 011 tests X = memory word against Y = 0 and skips when the test is true. It writes X into the accumulator only when the accumulator number is nonzero.
- R6: Operation 100 sets X = accumulator + 1 and operation 110 sets X = accumulator - 1. In both cases X is always written to the accumulator, tested against 0, and a jump follows when the test is true.
- R7: Operation 101 sets X = memory + 1 and operation 111 sets X = memory - 1. In both cases X is always written to memory, tested against 0, and a skip follows when the test is true. X is also written to the accumulator when the accumulator number is nonzero.
- R8: Increment and decrement wrap modulo 2^36: 36'hFFFFFFFFF + 1 gives 0, and 0 - 1 gives 36'hFFFFFFFFF. The count operations update even under the "never" test.
- R9: `pc_sel` is 00 for fall-through with `pc_next` = PC+1, 01 for skip with `pc_next` = PC+2, and 10 for jump with `pc_next` = E. All three wrap modulo 2^18.
- R10: Outputs are registered. A result appears exactly one cycle after the operation is presented. `result` carries X for operations 011 to 111, and `ac_wr_num` repeats the accumulator number. During reset all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation presented this cycle |
| opcode | input | 9 | Family, operation and test fields |
| ac_num | input | 4 | Accumulator number |
| ac_val | input | 36 | Accumulator contents |
| mem_val | input | 36 | Memory word at E |
| ea | input | 18 | Effective address E |
| pc | input | 18 | Current program counter |
| res_valid | output | 1 | Result registers hold an accepted operation |
| result | output | 36 | Value to write back |
| ac_we | output | 1 | Write `result` to accumulator `ac_wr_num` |
| ac_wr_num | output | 4 | Accumulator number for the write |
| mem_we | output | 1 | Write `result` to memory at E |
| pc_sel | output | 2 | 00 next, 01 skip, 10 jump |
| pc_next | output | 18 | Next program counter |

## Verification
Two functions can fall in the same cycle: a count-and-skip operation writes memory and, when the accumulator number is nonzero, also writes the accumulator, while it resolves a skip. The bench triggers this case by sweeping every operation and test code against values at the signed extremes, both with a zero and with a nonzero accumulator number. It judges all the strobes, the result and the program counter together against a model computed arithmetically. A program counter of 18'h3FFFF is included in the sweep so that a skip and the counter wrap-around happen in the same cycle.

// File: rtl/csj_exec_unit.sv
module csj_exec_unit #(
  parameter int W  = 36,
  parameter int AW = 18,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [8:0]    opcode,
  input  logic [RW-1:0] ac_num,
  input  logic [W-1:0]  ac_val,
  input  logic [W-1:0]  mem_val,
  input  logic [AW-1:0] ea,
  input  logic [AW-1:0] pc,
  output logic          res_valid,
  output logic [W-1:0]  result,
  output logic          ac_we,
  output logic [RW-1:0] ac_wr_num,
  output logic          mem_we,
  output logic [1:0]    pc_sel,
  output logic [AW-1:0] pc_next
);
  localparam logic [2:0] FAMILY = 3'b011;
  localparam logic [1:0] SEL_NEXT = 2'b00, SEL_SKIP = 2'b01, SEL_JUMP = 2'b10;

  wire       accept = op_valid && (opcode[8:6] == FAMILY);
  wire [2:0] kind   = opcode[5:3];
  wire [2:0] test   = opcode[2:0];
  wire       ac_nz  = (ac_num != '0);

  logic [W-1:0] base, x_val, y_val;
  logic         hit, jumps;

  always_comb begin
    base  = kind[0] ? mem_val : ac_val;
    y_val = '0;
    unique case (kind)
      3'b000: begin x_val = ac_val; y_val = {{(W-AW){1'b0}}, ea}; end
      3'b001: begin x_val = ac_val; y_val = mem_val; end
      3'b010: x_val = ac_val;
      3'b011: x_val = mem_val;
      3'b100, 3'b101: x_val = base + W'(1);
      default: x_val = base - W'(1);
    endcase
  end

  wire lt = $signed(x_val) < $signed(y_val);
  wire eq = (x_val == y_val);
  assign hit   = ((test[0] & lt) | (test[1] & eq)) ^ test[2];
  assign jumps = (kind == 3'b010) || (kind == 3'b100) || (kind == 3'b110);

  wire n_mem_we = kind[2] & kind[0];
  wire n_ac_we  = (kind[2] & ~kind[0]) | ((kind == 3'b011 || n_mem_we) && ac_nz);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      result    <= '0;
      ac_we     <= 1'b0;
      ac_wr_num <= '0;
      mem_we    <= 1'b0;
      pc_sel    <= SEL_NEXT;
      pc_next   <= '0;
    end else begin
      res_valid <= accept;
      ac_wr_num <= ac_num;
      result    <= (kind >= 3'b011) ? x_val : '0;
      ac_we     <= accept && n_ac_we;
      mem_we    <= accept && n_mem_we;
      if (accept && hit && jumps) begin
        pc_sel  <= SEL_JUMP;
        pc_next <= ea;
      end else if (accept && hit) begin
        pc_sel  <= SEL_SKIP;
        pc_next <= pc + AW'(2);
      end else begin
        pc_sel  <= SEL_NEXT;
        pc_next <= pc + AW'(1);
      end
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!ac_we && !mem_we && pc_sel == SEL_NEXT));

  assert_sel_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_sel != 2'b11);

  assert_jump_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_sel == SEL_JUMP) |-> (pc_next == $past(ea)));

  assert_skip_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_sel == SEL_SKIP) |-> (pc_next == $past(pc) + AW'(2)));

  assert_mem_only_count_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(opcode[5]) && $past(opcode[3])));

  assert_dual_write_needs_ac_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ac_we && mem_we) |-> (ac_wr_num != '0));

  assert_wrap_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(opcode[4:3]) == 2'b01 && $past(opcode[5]) && $past(mem_val) == '1)
      |-> (result == '0));

  assert_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(op_valid));
endmodule

// File: tb/csj_exec_unit_tb.sv
`timescale 1ns/1ps
module csj_exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [8:0]  opcode = '0;
  logic [3:0]  ac_num = '0;
  logic [35:0] ac_val = '0, mem_val = '0;
  logic [17:0] ea = '0, pc = '0;
  logic        res_valid, ac_we, mem_we;
  logic [35:0] result;
  logic [3:0]  ac_wr_num;
  logic [1:0]  pc_sel;
  logic [17:0] pc_next;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  csj_exec_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .ac_num(ac_num), .ac_val(ac_val), .mem_val(mem_val), .ea(ea), .pc(pc),
    .res_valid(res_valid), .result(result), .ac_we(ac_we), .ac_wr_num(ac_wr_num),
    .mem_we(mem_we), .pc_sel(pc_sel), .pc_next(pc_next));

  task automatic check(input string tag, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [35:0] word_of(input int i);
    case (i)
      0: return 36'h0;
      1: return 36'h1;
      2: return 36'hFFFFFFFFF;
      3: return 36'h7FFFFFFFF;
      4: return 36'h800000000;
      default: return 36'd123456;
    endcase
  endfunction

  function automatic logic [17:0] ea_of(input int i);
    case (i % 4)
      0: return 18'h0;
      1: return 18'h1;
      2: return 18'h3FFFF;
      default: return 18'd123456;
    endcase
  endfunction

  task automatic run_op(input logic [2:0] t, input logic [2:0] c, input logic [3:0] an,
                        input logic [35:0] a, input logic [35:0] m,
                        input logic [17:0] e, input logic [17:0] p);
    logic [35:0] x, y, exp_res;
    logic lt, eq, tst, jmp, exp_acw, exp_mw;
    logic [1:0] exp_sel;
    logic [17:0] exp_pc;
    string tg;
    @(negedge clk);
    op_valid = 1'b1; opcode = {3'b011, t, c}; ac_num = an;
    ac_val = a; mem_val = m; ea = e; pc = p;
    y = 36'h0;
    case (t)
      3'd0: begin x = a; y = {18'h0, e}; tg = "R3"; end
      3'd1: begin x = a; y = m; tg = "R3"; end
      3'd2: begin x = a; tg = "R4"; end
      3'd3: begin x = m; tg = "R5"; end
      3'd4: begin x = a + 36'd1; tg = "R6"; end
      3'd5: begin x = m + 36'd1; tg = "R7"; end
      3'd6: begin x = a - 36'd1; tg = "R6"; end
      default: begin x = m - 36'd1; tg = "R7"; end
    endcase
    lt = $signed(x) < $signed(y);
    eq = (x == y);
    case (c)
      3'd0: tst = 1'b0;
      3'd1: tst = lt;
      3'd2: tst = eq;
      3'd3: tst = lt || eq;
      3'd4: tst = 1'b1;
      3'd5: tst = !lt;
      3'd6: tst = !eq;
      default: tst = !lt && !eq;
    endcase
    jmp = (t == 3'd2 || t == 3'd4 || t == 3'd6);
    exp_sel = !tst ? 2'b00 : (jmp ? 2'b10 : 2'b01);
    exp_pc  = !tst ? p + 18'd1 : (jmp ? e : p + 18'd2);
    exp_mw  = (t == 3'd5 || t == 3'd7);
    exp_acw = (t == 3'd4 || t == 3'd6) || ((t == 3'd3 || exp_mw) && an != 4'd0);
    exp_res = (t >= 3'd3) ? x : 36'h0;
    @(negedge clk);
    op_valid = 1'b0;
    check("R10", "res_valid", {35'h0, res_valid}, 36'h1);
    check("R2", "pc_sel", {34'h0, pc_sel}, {34'h0, exp_sel});
    check("R9", "pc_next", {18'h0, pc_next}, {18'h0, exp_pc});
    check(tg, "ac_we", {35'h0, ac_we}, {35'h0, exp_acw});
    check(tg, "mem_we", {35'h0, mem_we}, {35'h0, exp_mw});
    if (t >= 3'd3) check("R8", "result", result, exp_res);
    else           check(tg, "result", result, exp_res);
    if (exp_acw) check("R10", "ac_wr_num", {32'h0, ac_wr_num}, {32'h0, an});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R10", "reset res_valid", {35'h0, res_valid}, 36'h0);
    check("R10", "reset ac_we", {35'h0, ac_we}, 36'h0);
    check("R10", "reset mem_we", {35'h0, mem_we}, 36'h0);
    rst_n = 1'b1;

    for (int t = 0; t < 8; t++)
      for (int c = 0; c < 8; c++)
        for (int i = 0; i < 6; i++)
          for (int j = 0; j < 6; j++)
            for (int k = 0; k < 2; k++) begin
              logic [17:0] p;
              p = (i == 2) ? 18'h3FFFF : 18'h00100 + 18'(i);
              run_op(3'(t), 3'(c), k ? 4'd5 : 4'd0,
                     word_of(i), word_of(j), (j == 5) ? 18'd123456 : ea_of(j + i), p);
            end

    // R8: wrap corners under the never test
    run_op(3'd5, 3'd0, 4'd0, 36'h0, 36'hFFFFFFFFF, 18'h10, 18'h20);
    run_op(3'd7, 3'd0, 4'd3, 36'h0, 36'h0, 18'h10, 18'h20);

    // R1: wrong family and no valid
    for (int f = 0; f < 8; f++) begin
      if (f == 3) continue;
      @(negedge clk);
      op_valid = 1'b1; opcode = {3'(f), 3'b101, 3'b100}; ac_num = 4'd7;
      mem_val = 36'h5; pc = 18'h40;
      @(negedge clk);
      op_valid = 1'b0;
      check("R1", "foreign res_valid", {35'h0, res_valid}, 36'h0);
      check("R1", "foreign writes", {34'h0, ac_we, mem_we}, 36'h0);
      check("R1", "foreign pc_sel", {34'h0, pc_sel}, 36'h0);
    end
    @(negedge clk);
    op_valid = 1'b0; opcode = 9'b011_101_100;
    @(negedge clk);
    check("R1", "idle res_valid", {35'h0, res_valid}, 36'h0);
    check("R1", "idle writes", {34'h0, ac_we, mem_we}, 36'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule